// File: doc/BRIEF.md
# Spin Lock Unit with Read Polling and Exponential Backoff

This block is a hardware mutual-exclusion lock shared by a set of requesters. It keeps one lock word and offers three ways to reach it: an atomic test-and-set that returns the old value and leaves the word set, a plain read, and a release that clears the word. Every requester has its own front-end. A requester starts it with a one-cycle acquire pulse, then sees its grant output stay high for as long as it owns the lock, and gives the lock back with a one-cycle release pulse.

Each front-end waits by polling the lock word with plain reads. It tries a test-and-set only after a read has shown the word clear. When a test-and-set returns a set word, the front-end sleeps for a backoff delay before it reads again. The delay is the base length multiplied by a power-of-two growth factor once for each failure since the last success, and it is clamped at a ceiling. Reads and test-and-sets from all front-ends go through a single shared access port. A round-robin arbiter grants that port to one requester per cycle, so each test-and-set is indivisible. The grant and operation type of the port are brought out so that traffic can be counted for each acquisition.

Top module: `tas_lock_unit`

## Requirements
- R1: While rst_ni is low and in the first cycle after it rises, grant_o, err_o, port_gnt_o and port_tas_o are all zero, the lock word is clear and the arbiter gives priority to requester 0.
- R2: An acquire pulse to an idle requester makes it request the shared port from the next cycle onward with plain reads (port_tas_o low when it is granted). It keeps reading for as long as a granted read returns a set lock word.
- R3: A granted read that returns a clear lock word makes that requester's next port request a test-and-set (port_tas_o high when it is granted).
- R4: A granted test-and-set returns the old lock word and leaves it set in the same cycle. If the old value was clear, grant_o of that requester rises in the following cycle and stays high until its release. At most one bit of grant_o is ever high.
- R5: After a granted test-and-set returns a set word, the requester makes no port request for exactly D cycles and then resumes reading. D = min(K_BASE * 2^(C_LOG2*i), BO_CAP), where i is the number of failed test-and-sets since its last successful acquire, counting this one.
- R6: A successful acquire resets the requester's failure count, so its next failure after a later acquire pulse waits K_BASE * 2^C_LOG2 cycles again.
- R7: A release pulse from the owner drops its grant_o in the next cycle. Any port access in the same cycle as that release sees the lock word as clear.
- R8: A release pulse from a requester that does not own the lock raises err_o for exactly the next cycle and has no effect: the owner keeps grant_o and no waiter can acquire.
- R9: At most one requester is granted the port per cycle. Priority rotates: after requester j is granted, the search starts at requester j+1 (modulo N_REQ).
- R10: An acquire pulse to a requester that is not idle (polling, trying, backing off or owning) is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| acq_i | input | N_REQ | Per-requester acquire pulse |
| rel_i | input | N_REQ | Per-requester release pulse |
| grant_o | output | N_REQ | High while the requester owns the lock |
| err_o | output | 1 | One-cycle flag for a release from a non-owner |
| port_gnt_o | output | N_REQ | One-hot grant of the shared lock-word port this cycle |
| port_tas_o | output | 1 | The granted port access this cycle is a test-and-set |

## Verification
The assertions check on every cycle that ownership is exclusive, that the port is granted to at most one requester, that a new owner only appears right after a test-and-set, that an owner keeps its grant until it releases and loses it the cycle after, and that err_o has a bad release behind it. Only the bench's scenarios can show the exact backoff lengths, how they clamp at the cap and restart after a success, the order in which the arbiter rotates, and that polling turns into a single test-and-set once the word reads clear. For these, a behavioural reference model runs alongside the design and checks every output in every cycle through contention, misuse and random traffic.

// File: rtl/tlk_pkg.sv
package tlk_pkg;
  typedef enum logic [2:0] {
    FE_IDLE,
    FE_POLL,
    FE_TAS,
    FE_WAIT,
    FE_OWN
  } fe_state_e;
endpackage

// File: rtl/tlk_rr_arb.sv
module tlk_rr_arb #(
  parameter int N_REQ = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_REQ-1:0] req_i,
  output logic [N_REQ-1:0] gnt_o
);
  localparam int PW = (N_REQ > 1) ? $clog2(N_REQ) : 1;

  logic [PW-1:0] ptr_q;
  logic [PW-1:0] ptr_nxt;
  logic          found;

  always_comb begin
    int idx;
    gnt_o   = '0;
    found   = 1'b0;
    ptr_nxt = ptr_q;
    for (int off = 0; off < N_REQ; off++) begin
      idx = int'(ptr_q) + off;
      if (idx >= N_REQ) idx = idx - N_REQ;
      if (!found && req_i[idx]) begin
        gnt_o[idx] = 1'b1;
        found      = 1'b1;
        ptr_nxt    = (idx == N_REQ - 1) ? '0 : PW'(idx + 1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else         ptr_q <= ptr_nxt;
  end
endmodule

// File: rtl/tlk_word.sv
module tlk_word (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,   // owner release, ordered before same-cycle access
  input  logic acc_i,
  input  logic tas_i,
  output logic rd_val_o,
  output logic lock_o
);
  logic lock_q;

  assign rd_val_o = clr_i ? 1'b0 : lock_q;
  assign lock_o   = lock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              lock_q <= 1'b0;
    else if (acc_i && tas_i)  lock_q <= 1'b1;
    else if (clr_i)           lock_q <= 1'b0;
  end
endmodule

// File: rtl/tlk_frontend.sv
module tlk_frontend
  import tlk_pkg::*;
#(
  parameter int K_BASE = 2,
  parameter int C_LOG2 = 1,
  parameter int BO_CAP = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic acq_i,
  input  logic rel_i,
  input  logic gnt_i,
  input  logic rd_val_i,
  output logic req_o,
  output logic tas_o,
  output logic held_o
);
  localparam int BO_W = $clog2(BO_CAP + 1);
  localparam int WW   = BO_W + C_LOG2;
  localparam logic [WW-1:0]   CAP_W = WW'(BO_CAP);
  localparam logic [BO_W-1:0] K_W   = BO_W'(K_BASE);

  fe_state_e       st_q;
  logic [BO_W-1:0] bo_len_q, cnt_q, grown;
  logic [WW-1:0]   wide;

  always_comb begin
    wide  = WW'(bo_len_q) << C_LOG2;
    grown = (wide > CAP_W) ? CAP_W[BO_W-1:0] : wide[BO_W-1:0];
  end

  assign req_o  = (st_q == FE_POLL) || (st_q == FE_TAS);
  assign tas_o  = (st_q == FE_TAS);
  assign held_o = (st_q == FE_OWN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= FE_IDLE;
      bo_len_q <= K_W;
      cnt_q    <= '0;
    end else begin
      unique case (st_q)
        FE_IDLE: if (acq_i) st_q <= FE_POLL;
        FE_POLL: if (gnt_i && !rd_val_i) st_q <= FE_TAS;
        FE_TAS: if (gnt_i) begin
          if (!rd_val_i) begin
            st_q     <= FE_OWN;
            bo_len_q <= K_W;
          end else begin
            st_q     <= FE_WAIT;
            bo_len_q <= grown;
            cnt_q    <= grown;
          end
        end
        FE_WAIT: begin
          if (cnt_q <= BO_W'(1)) st_q <= FE_POLL;
          else                   cnt_q <= cnt_q - BO_W'(1);
        end
        FE_OWN: if (rel_i) st_q <= FE_IDLE;
        default: st_q <= FE_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tas_lock_unit.sv
module tas_lock_unit #(
  parameter int N_REQ  = 4,
  parameter int K_BASE = 2,
  parameter int C_LOG2 = 1,
  parameter int BO_CAP = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_REQ-1:0] acq_i,
  input  logic [N_REQ-1:0] rel_i,
  output logic [N_REQ-1:0] grant_o,
  output logic             err_o,
  output logic [N_REQ-1:0] port_gnt_o,
  output logic             port_tas_o
);
  logic [N_REQ-1:0] fe_req, fe_tas, held, gnt;
  logic             rd_val, lock_q, rel_ok, err_q;

  assign rel_ok     = |(rel_i & held);
  assign port_tas_o = |(gnt & fe_tas);
  assign port_gnt_o = gnt;
  assign grant_o    = held;
  assign err_o      = err_q;

  tlk_rr_arb #(.N_REQ(N_REQ)) u_arb (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .req_i (fe_req),
    .gnt_o (gnt)
  );

  tlk_word u_word (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (rel_ok),
    .acc_i   (|gnt),
    .tas_i   (port_tas_o),
    .rd_val_o(rd_val),
    .lock_o  (lock_q)
  );

  for (genvar i = 0; i < N_REQ; i++) begin : g_fe
    tlk_frontend #(.K_BASE(K_BASE), .C_LOG2(C_LOG2), .BO_CAP(BO_CAP)) u_fe (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .acq_i   (acq_i[i]),
      .rel_i   (rel_i[i]),
      .gnt_i   (gnt[i]),
      .rd_val_i(rd_val),
      .req_o   (fe_req[i]),
      .tas_o   (fe_tas[i]),
      .held_o  (held[i])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= |(rel_i & ~held);
  end
endmodule

// File: rtl/tas_lock_chk.sv
module tas_lock_chk #(
  parameter int N_REQ = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_REQ-1:0] rel_i,
  input logic [N_REQ-1:0] grant_o,
  input logic             err_o,
  input logic [N_REQ-1:0] port_gnt_o,
  input logic             port_tas_o,
  input logic             lock_q
);
  AST_ONE_OWNER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o)); // R4
  AST_OWNER_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|grant_o) |-> lock_q); // R4
  AST_NEW_OWNER_TAS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(grant_o & ~$past(grant_o))) |-> $past(port_tas_o)); // R4
  AST_PORT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(port_gnt_o)); // R9
  AST_TAS_NEEDS_GNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    port_tas_o |-> (|port_gnt_o)); // R3
  AST_REL_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(grant_o & rel_i)) |=> ((grant_o & $past(grant_o & rel_i)) == '0)); // R7
  AST_OWNER_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|grant_o) && !(|(rel_i & grant_o))) |=> (grant_o == $past(grant_o))); // R8
  AST_ERR_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(|(rel_i & ~grant_o))); // R8
endmodule

bind tas_lock_unit tas_lock_chk #(.N_REQ(N_REQ)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .rel_i     (rel_i),
  .grant_o   (grant_o),
  .err_o     (err_o),
  .port_gnt_o(port_gnt_o),
  .port_tas_o(port_tas_o),
  .lock_q    (lock_q)
);

// File: tb/tb_tas_lock_unit.sv
module tb_tas_lock_unit;
  localparam int N   = 4;
  localparam int K   = 2;
  localparam int CL  = 1;
  localparam int CAP = 16;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [N-1:0] acq_i = '0, rel_i = '0;
  logic [N-1:0] grant_o, port_gnt_o;
  logic         err_o, port_tas_o;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // reference model: 0 idle, 1 poll, 2 tas, 3 wait, 4 own
  int m_st[N], m_bo[N], m_cnt[N], txn[N];
  int m_ptr, m_lock, m_err;
  int acqs = 0, txn_tot = 0;

  always #10 clk_i = ~clk_i;

  tas_lock_unit #(.N_REQ(N), .K_BASE(K), .C_LOG2(CL), .BO_CAP(CAP)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .acq_i(acq_i), .rel_i(rel_i),
    .grant_o(grant_o), .err_o(err_o), .port_gnt_o(port_gnt_o), .port_tas_o(port_tas_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int m_pick();
    for (int off = 0; off < N; off++) begin
      int idx;
      idx = (m_ptr + off) % N;
      if (m_st[idx] == 1 || m_st[idx] == 2) return idx;
    end
    return -1;
  endfunction

  task automatic m_init();
    for (int i = 0; i < N; i++) begin
      m_st[i] = 0; m_bo[i] = K; m_cnt[i] = 0; txn[i] = 0;
    end
    m_ptr = 0; m_lock = 0; m_err = 0;
  endtask

  task automatic m_step(input logic [N-1:0] a, input logic [N-1:0] r);
    int g, eff, nlock, err, rel_ok;
    rel_ok = 0; err = 0;
    for (int i = 0; i < N; i++)
      if (r[i]) begin
        if (m_st[i] == 4) rel_ok = 1; else err = 1;
      end
    eff = rel_ok ? 0 : m_lock;
    nlock = eff;
    g = m_pick();
    for (int i = 0; i < N; i++) begin
      case (m_st[i])
        0: if (a[i]) m_st[i] = 1;
        1: if (i == g && eff == 0) m_st[i] = 2;
        2: if (i == g) begin
          nlock = 1;
          if (eff == 0) begin m_st[i] = 4; m_bo[i] = K; end
          else begin
            m_bo[i] = (m_bo[i] * (1 << CL) > CAP) ? CAP : m_bo[i] * (1 << CL);
            m_cnt[i] = m_bo[i];
            m_st[i] = 3;
          end
        end
        3: if (m_cnt[i] <= 1) m_st[i] = 1; else m_cnt[i]--;
        4: if (r[i]) m_st[i] = 0;
        default: ;
      endcase
    end
    if (g >= 0) m_ptr = (g + 1) % N;
    m_lock = nlock;
    m_err  = err;
  endtask

  // compare at negedge, then drive inputs and advance model for the next posedge
  task automatic step(input logic [N-1:0] a, input logic [N-1:0] r);
    int g;
    logic [N-1:0] eg, eport;
    @(negedge clk_i);
    g = m_pick();
    eg = '0; eport = '0;
    for (int i = 0; i < N; i++) if (m_st[i] == 4) eg[i] = 1'b1;
    if (g >= 0) eport[g] = 1'b1;
    chk("R4 R6 R7 R10 grant_o", int'(grant_o), int'(eg));
    chk("R8 err_o", int'(err_o), m_err);
    chk("R2 R5 R9 port_gnt_o", int'(port_gnt_o), int'(eport));
    chk("R2 R3 port_tas_o", int'(port_tas_o), (g >= 0 && m_st[g] == 2) ? 1 : 0);
    for (int i = 0; i < N; i++) if (port_gnt_o[i]) txn[i]++;
    acq_i = a; rel_i = r;
    for (int i = 0; i < N; i++)
      if (m_st[i] == 2 && g == i && (m_lock == 0) && !(|(r & eg))) begin
      end
    begin
      int old_st[N];
      for (int i = 0; i < N; i++) old_st[i] = m_st[i];
      m_step(a, r);
      for (int i = 0; i < N; i++)
        if (old_st[i] != 4 && m_st[i] == 4) begin
          acqs++; txn_tot += txn[i]; txn[i] = 0;
        end
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step('0, '0);
  endtask

  // hold-and-release driver: release whoever owns after a short hold
  task automatic drain(input int cycles, input int hold);
    int held_for;
    held_for = 0;
    for (int k = 0; k < cycles; k++) begin
      logic [N-1:0] r;
      r = '0;
      if (|grant_o) begin
        held_for++;
        if (held_for >= hold) begin r = grant_o; held_for = 0; end
      end
      step('0, r);
    end
  endtask

  initial begin
    m_init();
    repeat (3) @(negedge clk_i);
    // R1: reset state
    chk("R1 grant_o in reset", int'(grant_o), 0);
    chk("R1 err_o in reset", int'(err_o), 0);
    chk("R1 port_gnt_o in reset", int'(port_gnt_o), 0);
    chk("R1 port_tas_o in reset", int'(port_tas_o), 0);
    rst_ni = 1'b1;
    m_step('0, '0);
    idle(2);

    // single requester, no contention
    step(4'b0001, '0);
    idle(4);
    step(4'b0001, '0);           // R10 ignored while owning
    idle(2);
    step('0, 4'b0001);
    idle(2);

    // owner plus three pollers, bad release, acquire while polling
    step(4'b0100, '0);
    idle(3);
    step(4'b1011, '0);
    idle(6);
    step(4'b0010, 4'b1000);      // R8 bad release, R10 acquire while polling
    idle(4);
    step('0, 4'b0100);           // owner releases: contention
    drain(200, 3);

    // repeated contention to drive backoff to the cap (R5, R6)
    for (int rnd = 0; rnd < 6; rnd++) begin
      step(4'b1111, '0);
      drain(150, 1);
    end

    // random traffic
    for (int k = 0; k < 3000; k++) begin
      logic [N-1:0] a, r;
      a = N'($urandom) & N'($urandom);
      r = '0;
      if ($urandom_range(0, 3) == 0) r = grant_o;
      if ($urandom_range(0, 40) == 0) r = r | N'(1 << $urandom_range(0, N - 1));
      step(a, r);
    end
    drain(300, 2);

    $display("acquisitions %0d, port transactions %0d", acqs, txn_tot);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule